// File: doc/BRIEF.md
# Prescaled Interval Timer with Watchdog

A single-channel interval timer sits behind a small register bus. It has three 32-bit registers: control, reload and flags. A prescaler divides the clock and produces a tick. Each tick decrements a down-counter. When the counter runs out, the timer either stops (one-shot) or reloads itself and keeps going (continuous). Each expiry sets a flag, and the flag drives a maskable interrupt request.

The same counter can act as a watchdog. In that mode an expiry produces a one-cycle reset pulse instead of a flag. Software restarts the count by writing a single key byte into the top byte of the control register, and that write leaves every control bit as it was. The bus is a single-cycle write strobe with per-byte enables. Read data is combinational from the address.

Top module: `prescaled_wdt_timer`

## Requirements
- R1: After reset the control, reload and flags registers read 0, and `irq` and `wdog_rst` are low.
- R2: Control is at offset 0x0 and keeps only bits 15, 12, 10, 8 and 2:0; every other bit reads 0. Reload is at offset 0x4, with the prescaler value in bits 31:16 and the terminal count in bits 15:0. Flags are at offset 0xC, and any other offset reads 0. Each byte lane is written only when its enable is set (`bus_be[k]` covers bits 8k+7:8k).
- R3: A prescaler value P divides the clock by P for P = 1..65535 and by 65536 for P = 0. A terminal count T gives an expiry max(T,1)·P clock edges after the edge that starts or restarts the count.
- R4: One-shot mode (control bit 10 clear, bit 15 clear): an expiry sets flag bit 0 and clears the run bit (control bit 12), and no further expiry follows.
- R5: Continuous mode (control bit 10 set): an expiry sets flag bit 0, keeps the run bit set, and reloads both counters, so expiries repeat every max(T,1)·P edges.
- R6: `irq` is high exactly when any of flag bits 3:0 is set and control bit 8 is set.
- R7: A write to the flags register with `bus_be[0]` set clears each flag bit written as 1. Bits written as 0, and writes with `bus_be[0]` clear, leave the flags unchanged.
- R8: Writing the reload register, or changing control bit 12 from 0 to 1, restarts both the prescaler and the counter. Rewriting the control register while bit 12 is already set does not restart them.
- R9: With control bit 15 set, an expiry pulses `wdog_rst` high for one cycle, leaves the flags unchanged, and reloads the counters, so the next pulse follows after the same interval.
- R10: A write to offset 0x0 with `bus_be` = 4'b1000 and 0xA5 on bits 31:24 is a key write and never changes the control register. When control bit 15 is set, a key write restarts the count. When bit 15 is clear, it has no effect on counting.
- R11: Writing 0 to control bits 12 and 15 stops an active watchdog, and no further `wdog_rst` pulse occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_be | input | 4 | Byte lane enables for the write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | Masked interrupt request |
| wdog_rst | output | 1 | One-cycle watchdog reset pulse |

## Verification
The bench builds the block with its default parameters: a 16-bit prescaler, a 16-bit counter and a 4-bit address. With the full-width prescaler, the divide-by-65536 case for a prescaler value of 0 fits in one run, and both 16-bit halves of the reload register can be checked per byte lane. The small prescaler and count values in the stimulus table measure the expiry interval to the exact edge in both one-shot and continuous runs. Directed runs cover masking, clearing flags, restarts, watchdog pulses, key writes and stopping.

// File: rtl/prescaled_wdt_timer.sv
module prescaled_wdt_timer #(
  parameter int ADDR_W = 4,
  parameter int PRE_W  = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic              wdog_rst
);
  localparam int FIELD_W = PRE_W + CNT_W;
  localparam logic [63:0] CMASK64 = (64'd1 << FIELD_W) - 64'd1;
  localparam logic [31:0] COUNT_MASK = CMASK64[31:0];
  localparam logic [31:0] MODE_MASK  = 32'h0000_9507;
  localparam int B_IE = 8, B_CONT = 10, B_EN = 12, B_WD = 15;
  localparam logic [ADDR_W-1:0] A_MODE  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(12);
  localparam logic [7:0] KEY = 8'hA5;

  function automatic logic [31:0] lane_merge(input logic [31:0] old_v,
                                              input logic [31:0] new_v,
                                              input logic [3:0]  be);
    logic [31:0] r;
    r = old_v;
    for (int k = 0; k < 4; k++)
      if (be[k]) r[8*k +: 8] = new_v[8*k +: 8];
    return r;
  endfunction

  logic [31:0]      mode_q, count_q;
  logic [3:0]       stat_q;
  logic [PRE_W-1:0] pre_cnt;
  logic [CNT_W-1:0] tc_cnt;
  logic             wdog_rst_q;

  wire mode_sel = bus_wr && (bus_addr == A_MODE);
  wire key_wr   = mode_sel && (bus_be == 4'b1000) && (bus_wdata[31:24] == KEY);
  wire mode_wr  = mode_sel && !key_wr;
  wire cnt_wr   = bus_wr && (bus_addr == A_COUNT);
  wire stat_wr  = bus_wr && (bus_addr == A_STAT) && bus_be[0];

  wire [31:0] mode_nx  = mode_wr ? (lane_merge(mode_q, bus_wdata, bus_be) & MODE_MASK) : mode_q;
  wire [31:0] count_nx = cnt_wr ? (lane_merge(count_q, bus_wdata, bus_be) & COUNT_MASK) : count_q;

  wire [PRE_W-1:0] pre_load = count_nx[CNT_W +: PRE_W] - PRE_W'(1);
  wire [PRE_W-1:0] pre_cur  = count_q[CNT_W +: PRE_W] - PRE_W'(1);

  wire running = mode_q[B_EN];
  wire wd_mode = mode_q[B_WD];
  wire tick    = running && (pre_cnt == '0);
  wire expire  = tick && (tc_cnt <= CNT_W'(1));
  wire reload  = cnt_wr || (mode_nx[B_EN] && !mode_q[B_EN]) || (key_wr && wd_mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= '0;
      count_q    <= '0;
      stat_q     <= '0;
      pre_cnt    <= '0;
      tc_cnt     <= '0;
      wdog_rst_q <= 1'b0;
    end else begin
      mode_q <= mode_nx;
      if (expire && !wd_mode && !mode_q[B_CONT] && !mode_wr)
        mode_q[B_EN] <= 1'b0;
      count_q <= count_nx;

      if (reload) begin
        pre_cnt <= pre_load;
        tc_cnt  <= count_nx[CNT_W-1:0];
      end else if (running) begin
        if (tick) begin
          pre_cnt <= pre_cur;
          tc_cnt  <= expire ? count_q[CNT_W-1:0] : tc_cnt - CNT_W'(1);
        end else begin
          pre_cnt <= pre_cnt - PRE_W'(1);
        end
      end

      stat_q <= (stat_q & ~(stat_wr ? bus_wdata[3:0] : 4'b0000))
              | {3'b000, expire && !wd_mode};
      wdog_rst_q <= expire && wd_mode;
    end
  end

  always_comb begin
    case (bus_addr)
      A_MODE:  bus_rdata = mode_q;
      A_COUNT: bus_rdata = count_q;
      A_STAT:  bus_rdata = {28'd0, stat_q};
      default: bus_rdata = '0;
    endcase
  end

  assign irq      = (|stat_q) && mode_q[B_IE];
  assign wdog_rst = wdog_rst_q;

  AST_ONESHOT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(stat_q[0]) && !$past(mode_q[B_CONT]) && !$past(bus_wr)) |-> !mode_q[B_EN]); // R4
  AST_CONT_KEEPS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(stat_q[0]) && $past(mode_q[B_CONT]) && !$past(bus_wr)) |-> mode_q[B_EN]); // R5
  AST_WD_PULSE_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_rst |-> $past(mode_q[B_WD])); // R9
  AST_WD_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_rst |-> !$rose(stat_q[0])); // R9
  AST_KEY_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && mode_q[B_WD]) |=> $stable(mode_q)); // R10
endmodule

// File: tb/prescaled_wdt_timer_tb.sv
module prescaled_wdt_timer_tb;
  localparam int CLK_P = 10;
  localparam int NV = 8;
  // {prescaler[52:37], terminal[36:21], continuous[20], expected edges[19:0]}
  localparam logic [52:0] VEC [0:NV-1] = '{
    {16'd1, 16'd1,   1'b0, 20'd1},
    {16'd1, 16'd5,   1'b0, 20'd5},
    {16'd3, 16'd4,   1'b1, 20'd12},
    {16'd2, 16'd0,   1'b0, 20'd2},
    {16'd7, 16'd3,   1'b1, 20'd21},
    {16'd4, 16'd1,   1'b1, 20'd4},
    {16'd1, 16'd300, 1'b0, 20'd300},
    {16'd0, 16'd1,   1'b0, 20'd65536}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, wdog_rst;
  int cyc = 0;
  int checks = 0;
  int errors = 0;

  prescaled_wdt_timer u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .wdog_rst(wdog_rst)
  );

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic bw(input logic [3:0] a, input logic [3:0] be, input logic [31:0] d);
    bus_addr = a; bus_be = be; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_ev(input bit on_rst, input int limit, output int t);
    int s;
    s = cyc;
    while (!(on_rst ? wdog_rst : irq) && (cyc - s) < limit) @(negedge clk);
    t = cyc;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int s, t, k, pulses;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(4'h0, d); chk("R1 mode", d, 32'h0);
    rd(4'h4, d); chk("R1 count", d, 32'h0);
    rd(4'hC, d); chk("R1 status", d, 32'h0);
    chk("R1 irq", {31'd0, irq}, 32'h0);
    chk("R1 wdog_rst", {31'd0, wdog_rst}, 32'h0);

    // R2 register map and byte lanes
    bw(4'h4, 4'b0011, 32'h1234_5678); rd(4'h4, d); chk("R2 low lanes", d, 32'h0000_5678);
    bw(4'h4, 4'b1100, 32'hABCD_0000); rd(4'h4, d); chk("R2 high lanes", d, 32'hABCD_5678);
    rd(4'h8, d); chk("R2 unmapped", d, 32'h0);
    bw(4'h0, 4'b0111, 32'hFFFF_FFFF); rd(4'h0, d); chk("R2 mode mask", d, 32'h0000_9507);
    bw(4'h0, 4'b1000, 32'h5A00_0000); rd(4'h0, d); chk("R2 top byte", d, 32'h0000_9507);
    bw(4'h0, 4'hF, 32'h0);

    // R3/R4/R5 table of intervals
    for (int i = 0; i < NV; i++) begin
      logic [15:0] p, tc;
      logic        cont;
      int          exp;
      p = VEC[i][52:37]; tc = VEC[i][36:21]; cont = VEC[i][20]; exp = int'(VEC[i][19:0]);
      bw(4'h4, 4'hF, {p, tc});
      bw(4'h0, 4'hF, 32'h0000_1104 | (cont ? 32'h400 : 32'h0));
      s = cyc;
      wait_ev(1'b0, exp + 50, t);
      chk("R3 interval", t - s, exp);
      if (cont) begin
        bw(4'hC, 4'h1, 32'h1);
        wait_ev(1'b0, exp + 50, t);
        chk("R5 second interval", t - s, 2 * exp);
        rd(4'h0, d); chk("R5 still running", d, 32'h0000_1504);
      end else begin
        rd(4'h0, d); chk("R4 enable cleared", d, 32'h0000_0104);
        bw(4'hC, 4'h1, 32'h1);
        repeat (10) @(negedge clk);
        chk("R4 no further expiry", {31'd0, irq}, 32'h0);
      end
      bw(4'h0, 4'hF, 32'h0);
      bw(4'hC, 4'h1, 32'h1);
    end

    // R6 masking, R7 write-one-to-clear
    bw(4'h4, 4'hF, {16'd1, 16'd3});
    bw(4'h0, 4'hF, 32'h0000_1004);
    repeat (6) @(negedge clk);
    chk("R6 masked irq", {31'd0, irq}, 32'h0);
    rd(4'hC, d); chk("R6 flag set while masked", d, 32'h1);
    bw(4'h0, 4'hF, 32'h0000_0104);
    chk("R6 unmasked irq", {31'd0, irq}, 32'h1);
    bw(4'hC, 4'hF, 32'h0); rd(4'hC, d); chk("R7 zero write keeps", d, 32'h1);
    bw(4'hC, 4'b1110, 32'hF); rd(4'hC, d); chk("R7 lane0 off keeps", d, 32'h1);
    bw(4'hC, 4'h1, 32'h1); rd(4'hC, d); chk("R7 cleared", d, 32'h0);
    chk("R7 irq low", {31'd0, irq}, 32'h0);

    // R8 restart rules
    bw(4'h4, 4'hF, {16'd1, 16'd10});
    bw(4'h0, 4'hF, 32'h0000_1104);
    repeat (4) @(negedge clk);
    bw(4'h4, 4'hF, {16'd1, 16'd10});
    s = cyc;
    wait_ev(1'b0, 60, t); chk("R8 reload write restarts", t - s, 10);
    bw(4'h0, 4'hF, 32'h0); bw(4'hC, 4'h1, 32'h1);
    bw(4'h0, 4'hF, 32'h0000_1104);
    s = cyc;
    repeat (4) @(negedge clk);
    bw(4'h0, 4'hF, 32'h0000_1104);
    wait_ev(1'b0, 60, t); chk("R8 mode rewrite no restart", t - s, 10);
    bw(4'h0, 4'hF, 32'h0); bw(4'hC, 4'h1, 32'h1);

    // R10 key ignored outside watchdog mode
    bw(4'h0, 4'hF, 32'h0000_1104);
    s = cyc;
    repeat (3) @(negedge clk);
    bw(4'h0, 4'b1000, 32'hA500_0000);
    rd(4'h0, d); chk("R10 key keeps mode", d, 32'h0000_1104);
    wait_ev(1'b0, 60, t); chk("R10 key no restart", t - s, 10);
    bw(4'h0, 4'hF, 32'h0); bw(4'hC, 4'h1, 32'h1);

    // R9 watchdog expiry
    bw(4'h4, 4'hF, {16'd2, 16'd3});
    bw(4'h0, 4'hF, 32'h0000_9104);
    s = cyc;
    wait_ev(1'b1, 60, t); chk("R9 first pulse", t - s, 6);
    rd(4'hC, d); chk("R9 no flag", d, 32'h0);
    chk("R9 no irq", {31'd0, irq}, 32'h0);
    @(negedge clk);
    chk("R9 one-cycle pulse", {31'd0, wdog_rst}, 32'h0);
    wait_ev(1'b1, 60, t); chk("R9 reload interval", t - s, 12);
    repeat (2) @(negedge clk);
    // R10 key restart in watchdog mode
    bw(4'h0, 4'b1000, 32'hA500_0000);
    k = cyc;
    rd(4'h0, d); chk("R10 key keeps wd mode", d, 32'h0000_9104);
    wait_ev(1'b1, 60, t); chk("R10 key restart", t - k, 6);

    // R11 stop the watchdog
    bw(4'h0, 4'hF, 32'h0);
    pulses = 0;
    for (int j = 0; j < 30; j++) begin
      @(negedge clk);
      if (wdog_rst) pulses++;
    end
    chk("R11 no pulse after stop", pulses, 0);
    rd(4'h0, d); chk("R11 mode cleared", d, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule